// File: doc/BRIEF.md
# Regulator Supervisory Fault Latch

This block is the digital supervisor of a two-output supply made of a switching buck stage and a linear pass stage. Each cycle it takes flags that analog comparators have already turned into clean synchronous bits:

- supply above its rising threshold
- supply below its falling threshold
- under-voltage on the buck feedback
- under-voltage on the linear feedback
- over-current across the low-side switch

It also takes an active-low disable input and a flag that reports the end of the soft-start ramp. From these it drives enables for the high-side gate, the low-side gate and the linear drive. It also gives a soft-start request and a two-bit code that says why the outputs were latched off.

A five-state machine does the work:

- `ST_POR` (supply not good)
- `ST_HOLD` (disabled)
- `ST_RAMP` (soft-start)
- `ST_RUN` (regulating)
- `ST_FAULT` (latched off)

The transitions are:

- power-good: `ST_POR` to `ST_RAMP`, or to `ST_HOLD` when disabled.
- release: `ST_HOLD` to `ST_RAMP`.
- ramp-done: `ST_RAMP` to `ST_RUN`.
- trip: `ST_RAMP`/`ST_RUN` to `ST_FAULT`.
- disable: any running or faulted state to `ST_HOLD`.
- brown-out: any state to `ST_POR`.

A trip on either stage turns off all three enables together. Only a brown-out followed by a new power-good, or a disable low-then-high cycle, lets the outputs run again. Either of these restarts soft-start.

All outputs are decoded from the registered state. Each reaction therefore appears on the ports one clock edge after the input flags that cause it are sampled.

Top module: `sup_latch_ctrl`

## Requirements
- R1: After reset, all three enables and the soft-start request are 0 and the fault code is 2'b00.
- R2: The supply hysteresis works as follows. In `ST_POR`, only the rising flag starts operation. The falling flag sends every state to `ST_POR` on the next edge, with all enables and the soft-start request at 0. When both supply flags are high together, the falling flag wins.
- R3: On power-good with `dis_n_i` high, the next edge enters `ST_RAMP`. All three enables are then 1 and `ss_req_o` is 1.
- R4: In `ST_RAMP`, `ss_done_i` moves the block to `ST_RUN` on the next edge. The enables stay 1 and `ss_req_o` drops to 0.
- R5: Both under-voltage flags are ignored in `ST_RAMP`. They change neither the enables nor the fault code.
- R6: In `ST_RUN`, either under-voltage flag turns off all three enables on the next edge and sets the fault code to 2'b01.
- R7: In `ST_RAMP` or `ST_RUN`, the over-current flag turns off all three enables on the next edge and sets the fault code to 2'b10. Over-current outranks a simultaneous under-voltage.
- R8: The first fault wins. While latched, the fault code and the off enables hold, whatever the fault flags and `ss_done_i` do.
- R9: `dis_n_i` low forces all enables off on the next edge and keeps the fault code. Its later release starts a new soft-start and clears the code to 2'b00.
- R10: The fault code survives a brown-out while in `ST_POR`. The following power-good restarts soft-start with the code cleared.
- R11: When several inputs are active at once, the order of precedence is:
  1. falling supply flag
  2. disable
  3. fault
  4. soft-start done

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sup_rise_i | input | 1 | Supply above rising threshold |
| sup_fall_i | input | 1 | Supply below falling threshold |
| buck_uv_i | input | 1 | Buck feedback below half reference |
| lin_uv_i | input | 1 | Linear feedback below half reference |
| ocp_i | input | 1 | Low-side drop above over-current trip |
| dis_n_i | input | 1 | Disable, active low |
| ss_done_i | input | 1 | Soft-start ramp finished |
| hs_en_o | output | 1 | High-side gate enable |
| ls_en_o | output | 1 | Low-side gate enable |
| lin_en_o | output | 1 | Linear drive enable |
| fault_code_o | output | 2 | Latched cause: 00 none, 01 under-voltage, 10 over-current |
| ss_req_o | output | 1 | Soft-start request |

## Verification
The outputs are a Moore decode of the state, so a wrong state shows at the ports one edge after the stimulus. There are three signs of it:

- enables that stay up after a trip or brown-out,
- a soft-start request that appears without a restart,
- a fault code that changes while latched.

`ST_FAULT` and `ST_HOLD` look the same at the ports. They are told apart by the next release or fault flag, because only `ST_HOLD` restarts on `dis_n_i` high. A reference model in the bench follows every cycle of a long random run, so a wrong branch is caught in the cycle after it is taken.

// File: rtl/sup_pkg.sv
package sup_pkg;

    localparam int FAULT_W = 2;
    localparam int UV_N    = 2;

    typedef enum logic [2:0] {
        ST_POR,
        ST_HOLD,
        ST_RAMP,
        ST_RUN,
        ST_FAULT
    } sup_state_t;

    typedef enum logic [FAULT_W-1:0] {
        FC_NONE = 2'b00,
        FC_UV   = 2'b01,
        FC_OCP  = 2'b10
    } fault_code_t;

endpackage

// File: rtl/sup_fault_arb.sv
module sup_fault_arb
    import sup_pkg::*;
#(
    parameter int N_UV = UV_N
) (
    input  logic            uv_armed_i,
    input  logic            oc_armed_i,
    input  logic [N_UV-1:0] uv_flags_i,
    input  logic            ocp_i,
    output logic            hit_o,
    output fault_code_t     kind_o
);

    logic uv_any;
    logic uv_hit;
    logic oc_hit;

    assign uv_any = |uv_flags_i;
    assign uv_hit = uv_armed_i && uv_any;
    assign oc_hit = oc_armed_i && ocp_i;

    always_comb begin
        hit_o  = uv_hit || oc_hit;
        kind_o = FC_NONE;
        if (oc_hit) begin
            kind_o = FC_OCP;
        end else if (uv_hit) begin
            kind_o = FC_UV;
        end
    end

endmodule

// File: rtl/sup_fault_reg.sv
module sup_fault_reg
    import sup_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        set_i,
    input  logic        clear_i,
    input  fault_code_t kind_i,
    output fault_code_t code_o
);

    fault_code_t code_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= FC_NONE;
        end else if (clear_i) begin
            code_q <= FC_NONE;
        end else if (set_i && (code_q == FC_NONE)) begin
            code_q <= kind_i;
        end
    end

    assign code_o = code_q;

endmodule

// File: rtl/sup_latch_ctrl.sv
module sup_latch_ctrl
    import sup_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sup_rise_i,
    input  logic               sup_fall_i,
    input  logic               buck_uv_i,
    input  logic               lin_uv_i,
    input  logic               ocp_i,
    input  logic               dis_n_i,
    input  logic               ss_done_i,
    output logic               hs_en_o,
    output logic               ls_en_o,
    output logic               lin_en_o,
    output logic [FAULT_W-1:0] fault_code_o,
    output logic               ss_req_o
);

    sup_state_t  st_q;
    sup_state_t  st_nx;
    logic        flt_hit;
    fault_code_t flt_kind;
    fault_code_t code;
    logic        flt_set;
    logic        flt_clr;
    logic        uv_armed;
    logic        oc_armed;

    assign uv_armed = (st_q == ST_RUN);
    assign oc_armed = (st_q == ST_RAMP) || (st_q == ST_RUN);

    sup_fault_arb #(.N_UV(UV_N)) arb_i (
        .uv_armed_i (uv_armed),
        .oc_armed_i (oc_armed),
        .uv_flags_i ({lin_uv_i, buck_uv_i}),
        .ocp_i      (ocp_i),
        .hit_o      (flt_hit),
        .kind_o     (flt_kind)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_POR;
        end else begin
            st_q <= st_nx;
        end
    end

    // transitions; precedence: brown-out, disable, trip, ramp-done
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_POR: begin
                if (!sup_fall_i && sup_rise_i) begin
                    st_nx = dis_n_i ? ST_RAMP : ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (sup_fall_i) begin
                    st_nx = ST_POR;
                end else if (dis_n_i) begin
                    st_nx = ST_RAMP;
                end
            end
            ST_RAMP, ST_RUN: begin
                if (sup_fall_i) begin
                    st_nx = ST_POR;
                end else if (!dis_n_i) begin
                    st_nx = ST_HOLD;
                end else if (flt_hit) begin
                    st_nx = ST_FAULT;
                end else if ((st_q == ST_RAMP) && ss_done_i) begin
                    st_nx = ST_RUN;
                end
            end
            ST_FAULT: begin
                if (sup_fall_i) begin
                    st_nx = ST_POR;
                end else if (!dis_n_i) begin
                    st_nx = ST_HOLD;
                end
            end
            default: st_nx = ST_POR;
        endcase
    end

    assign flt_set = (st_nx == ST_FAULT) && (st_q != ST_FAULT);
    assign flt_clr = (st_nx == ST_RAMP) && (st_q != ST_RAMP);

    sup_fault_reg code_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (flt_set),
        .clear_i (flt_clr),
        .kind_i  (flt_kind),
        .code_o  (code)
    );

    // Moore output decode
    always_comb begin
        hs_en_o  = 1'b0;
        ls_en_o  = 1'b0;
        lin_en_o = 1'b0;
        ss_req_o = 1'b0;
        unique case (st_q)
            ST_RAMP: begin
                hs_en_o  = 1'b1;
                ls_en_o  = 1'b1;
                lin_en_o = 1'b1;
                ss_req_o = 1'b1;
            end
            ST_RUN: begin
                hs_en_o  = 1'b1;
                ls_en_o  = 1'b1;
                lin_en_o = 1'b1;
            end
            ST_POR, ST_HOLD, ST_FAULT: begin
                hs_en_o  = 1'b0;
            end
            default: begin
                hs_en_o  = 1'b0;
            end
        endcase
    end

    assign fault_code_o = code;

endmodule

// File: rtl/sup_latch_chk.sv
module sup_latch_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sup_fall_i,
    input logic       buck_uv_i,
    input logic       lin_uv_i,
    input logic       ocp_i,
    input logic       dis_n_i,
    input logic       ss_done_i,
    input logic       hs_en_o,
    input logic       ls_en_o,
    input logic       lin_en_o,
    input logic [1:0] fault_code_o,
    input logic       ss_req_o
);

    // R2
    brownout_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sup_fall_i |=> (!hs_en_o && !ls_en_o && !lin_en_o && !ss_req_o));

    // R4
    ramp_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_req_o && ss_done_i && dis_n_i && !sup_fall_i && !ocp_i)
        |=> (hs_en_o && !ss_req_o));

    // R5
    ramp_uv_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_req_o && dis_n_i && !sup_fall_i && !ocp_i)
        |=> (hs_en_o && lin_en_o && fault_code_o == 2'b00));

    // R6
    run_uv_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_en_o && !ss_req_o && (buck_uv_i || lin_uv_i) && !ocp_i
         && dis_n_i && !sup_fall_i)
        |=> (!hs_en_o && !ls_en_o && !lin_en_o && fault_code_o == 2'b01));

    // R7
    ocp_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_en_o && ocp_i && dis_n_i && !sup_fall_i)
        |=> (!hs_en_o && !ls_en_o && !lin_en_o && fault_code_o == 2'b10));

    // R8
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_code_o != 2'b00) |=> ($stable(fault_code_o) || ss_req_o));

    // R9
    disable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dis_n_i && !sup_fall_i)
        |=> (!hs_en_o && !lin_en_o && $stable(fault_code_o)));

    // R3
    always @(negedge clk) begin
        if (rst_n) begin
            enables_agree_chk: assert ((hs_en_o == ls_en_o) && (hs_en_o == lin_en_o));
        end
    end

endmodule

bind sup_latch_ctrl sup_latch_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .sup_fall_i   (sup_fall_i),
    .buck_uv_i    (buck_uv_i),
    .lin_uv_i     (lin_uv_i),
    .ocp_i        (ocp_i),
    .dis_n_i      (dis_n_i),
    .ss_done_i    (ss_done_i),
    .hs_en_o      (hs_en_o),
    .ls_en_o      (ls_en_o),
    .lin_en_o     (lin_en_o),
    .fault_code_o (fault_code_o),
    .ss_req_o     (ss_req_o)
);

// File: tb/sup_latch_ctrl_tb.sv
`timescale 1ns/1ps
module sup_latch_ctrl_tb_top;

    localparam int M_POR = 0, M_HOLD = 1, M_RAMP = 2, M_RUN = 3, M_FLT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rise = 1'b0, fall = 1'b0, buv = 1'b0, luv = 1'b0, oc = 1'b0;
    logic dn = 1'b1, ssd = 1'b0;
    logic hs, ls, lin, ss;
    logic [1:0] code;

    int n_chk = 0;
    int n_fail = 0;
    int m_st = M_POR;
    logic [1:0] m_code = 2'b00;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sup_latch_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .sup_rise_i(rise), .sup_fall_i(fall),
        .buck_uv_i(buv), .lin_uv_i(luv), .ocp_i(oc), .dis_n_i(dn),
        .ss_done_i(ssd), .hs_en_o(hs), .ls_en_o(ls), .lin_en_o(lin),
        .fault_code_o(code), .ss_req_o(ss)
    );

    function automatic int ref_next(int st);
        int nx = st;
        case (st)
            M_POR:  if (!fall && rise) nx = dn ? M_RAMP : M_HOLD;
            M_HOLD: if (fall) nx = M_POR; else if (dn) nx = M_RAMP;
            M_RAMP, M_RUN: begin
                if (fall) nx = M_POR;
                else if (!dn) nx = M_HOLD;
                else if (oc || (st == M_RUN && (buv || luv))) nx = M_FLT;
                else if (st == M_RAMP && ssd) nx = M_RUN;
            end
            default: if (fall) nx = M_POR; else if (!dn) nx = M_HOLD;
        endcase
        return nx;
    endfunction

    task automatic cyc(input logic r, f, b, l, o, d, s);
        int nx;
        @(negedge clk);
        rise = r; fall = f; buv = b; luv = l; oc = o; dn = d; ssd = s;
        nx = ref_next(m_st);
        if (nx == M_FLT && m_st != M_FLT && m_code == 2'b00) m_code = oc ? 2'b10 : 2'b01;
        if (nx == M_RAMP && m_st != M_RAMP) m_code = 2'b00;
        m_st = nx;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag);
        logic en_e = (m_st == M_RAMP) || (m_st == M_RUN);
        logic ss_e = (m_st == M_RAMP);
        n_chk++;
        if (hs !== en_e || ls !== en_e || lin !== en_e || ss !== ss_e || code !== m_code) begin
            n_fail++;
            $display("FAIL %s: got hs=%b ls=%b lin=%b ss=%b code=%b, expected en=%b ss=%b code=%b",
                     tag, hs, ls, lin, ss, code, en_e, ss_e, m_code);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        check("R1 reset state");
        cyc(1,1,0,0,0,1,0); check("R2 fall beats rise");
        cyc(0,0,0,0,0,1,0); check("R2 no rise stays off");
        cyc(1,0,0,0,0,1,0); check("R3 power-good enters ramp");
        cyc(0,0,1,1,0,1,0); check("R5 uv ignored in ramp");
        cyc(0,0,0,0,0,1,1); check("R4 ramp done");
        cyc(0,0,0,1,0,1,0); check("R6 linear uv trip");
        cyc(0,0,1,0,1,1,1); check("R8 first fault holds");
        cyc(0,0,0,0,0,1,0); check("R8 latch persists");
        cyc(0,0,0,0,0,0,0); check("R9 disable keeps code");
        cyc(0,0,0,0,0,1,0); check("R9 release restarts");
        cyc(0,0,1,0,1,1,0); check("R7 ocp beats uv in ramp");
        cyc(0,1,0,0,0,1,0); check("R10 brown-out keeps code");
        cyc(1,0,0,0,0,1,0); check("R10 power-good clears");
        cyc(0,0,0,0,0,1,1); check("R4 into run");
        cyc(0,0,1,0,0,1,0); check("R6 buck uv trip");
        cyc(0,0,0,0,0,0,0); cyc(0,0,0,0,0,1,0); cyc(0,0,0,0,0,1,1);
        check("R9 back to run");
        cyc(0,1,0,0,1,0,0); check("R11 fall beats disable and ocp");
        cyc(1,0,0,0,0,0,0); check("R11 power-good while disabled holds");
        cyc(0,0,0,0,1,1,0); check("R11 release ignores ocp in hold");
        cyc(0,0,0,0,1,0,1); check("R11 disable beats ocp");
        for (int i = 0; i < 5000; i++) begin
            logic nd = dn;
            if ($urandom % 24 == 0) nd = ~dn;
            cyc(($urandom % 4) == 0, ($urandom % 60) == 0, ($urandom % 16) == 0,
                ($urandom % 16) == 0, ($urandom % 40) == 0, nd, ($urandom % 8) == 0);
            check("R2/R6/R7/R8/R11 random");
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule